// File: doc/BRIEF.md
# Dual-Bank Second-Order IIR Compensator

This block is the fixed-point compensator of a digital current loop. Each accepted error sample produces one control word from a second-order recursive filter: three feed-forward taps on the error history and two feedback taps on the output history. The result is clamped between a lower and an upper limit. The clamped value is both the output and the value kept as output history. Error samples enter on a valid/ready stream and control words leave on a second valid/ready stream. The output stage is a single register. A new sample is taken only when that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and `in_ready` is low.

Every filter setting lives in two register banks: five coefficients and the two clamp limits. Exactly one bank feeds the arithmetic at a time. The host write port always targets the other bank, so a coefficient set can be built up while the loop runs. A pulse on `swap_req` is remembered until the next accepted sample. At that sample the bank roles exchange, and that sample is already computed entirely from the newly active bank. Which bank to prepare, for example for low or high line voltage, is decided outside the block.

Top module: `iirc_core`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and `bank_sel` is 0. In both banks all coefficients and all history are zero, the lower limit is -32768 and the upper limit is 32767.
- R2: For each accepted sample e[n], the unclamped result is floor((b0·e[n] + b1·e[n-1] + b2·e[n-2] − a1·y[n-1] − a2·y[n-2]) / 2^14). The coefficients are 18-bit two's complement values with 14 fraction bits.
- R3: The result is clamped in this order: above the upper limit it becomes the upper limit; otherwise, below the lower limit it becomes the lower limit. The clamped value is stored as y history. Limits are the low 16 bits of the written word, sign-extended.
- R4: Host writes use the following word addresses: 0=b0, 1=b1, 2=b2, 3=a1, 4=a2, 5=lower limit, 6=upper limit. Address 7 is ignored. A write goes to the bank that is inactive after that clock edge.
- R5: Writes never change the coefficients or limits used for samples computed before the next bank swap.
- R6: A `swap_req` pulse is held pending until the next accepted sample. That sample uses the other bank, and `bank_sel` toggles at that edge. Several requests before one accepted sample cause a single swap. A request in the same cycle as an accept applies at the following accept.
- R7: A write in the same cycle as an accept that applies a pending swap lands in the bank that has just become inactive.
- R8: `in_ready` equals (not `out_valid` or `out_ready`) and not `clr`. An accepted sample sets `out_valid` at the next edge. An output held under back-pressure keeps its value.
- R9: `clr` zeroes all error and output history and blocks acceptance in that cycle. The output register is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous history clear |
| in_valid | input | 1 | Error sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_err | input | 16 | Signed error sample |
| out_valid | output | 1 | Control word valid |
| out_ready | input | 1 | Downstream takes the control word |
| out_ctl | output | 16 | Signed clamped control word |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write word address |
| wr_data | input | 18 | Host write data |
| swap_req | input | 1 | Request to exchange active and inactive bank |
| bank_sel | output | 1 | Index of the active bank |

## Verification
The hardest case to reach is a host write that arrives in the very cycle an accept consumes a pending swap, possibly while output back-pressure is toggling. The wrong target bank in that cycle corrupts the live coefficients without any visible glitch until much later. The stimulus raises `swap_req`, stalls, and then issues a write together with the accepting sample. A long random phase then mixes writes, swap pulses, clears and stalls on every cycle. A behavioural model tracks both banks and the pending flag, so every misrouted write shows up as a wrong output word.

// File: rtl/iirc_pkg.sv
package iirc_pkg;
  localparam int NREG = 7;
  localparam int AW   = $clog2(NREG);
  typedef enum logic [AW-1:0] {
    IDX_B0 = 3'd0,
    IDX_B1 = 3'd1,
    IDX_B2 = 3'd2,
    IDX_A1 = 3'd3,
    IDX_A2 = 3'd4,
    IDX_LO = 3'd5,
    IDX_HI = 3'd6
  } coef_idx_e;
endpackage

// File: rtl/iirc_bank_store.sv
module iirc_bank_store
  import iirc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [CW-1:0]        wr_data,
  input  logic                 wr_bank,
  input  logic                 act_bank,
  output logic [NREG*CW-1:0]   act_coef
);
  localparam int NBANK = 2;

  logic [NBANK-1:0][NREG*CW-1:0] flat;

  function automatic logic [CW-1:0] rst_val(input int idx);
    logic [CW-1:0] v;
    if (idx == int'(IDX_LO))      v = {{(CW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    else if (idx == int'(IDX_HI)) v = {{(CW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    else                          v = '0;
    return v;
  endfunction

  logic is_limit;
  logic [CW-1:0] wr_val;
  assign is_limit = (wr_addr == IDX_LO) || (wr_addr == IDX_HI);
  assign wr_val   = is_limit ? CW'($signed(wr_data[DW-1:0])) : wr_data;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CW-1:0] r [NREG];
    logic          hit;
    assign hit = wr_en && (wr_bank == 1'(g)) && (int'(wr_addr) < NREG);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NREG; i++) r[i] <= rst_val(i);
      end else if (hit) begin
        r[wr_addr] <= wr_val;
      end
    end

    always_comb begin
      for (int i = 0; i < NREG; i++) flat[g][i*CW +: CW] = r[i];
    end
  end

  assign act_coef = flat[act_bank];
endmodule

// File: rtl/iirc_mac.sv
module iirc_mac
  import iirc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int FRAC = 14
) (
  input  logic [NREG*CW-1:0]  coef,
  input  logic signed [DW-1:0] e0,
  input  logic signed [DW-1:0] e1,
  input  logic signed [DW-1:0] e2,
  input  logic signed [DW-1:0] y1,
  input  logic signed [DW-1:0] y2,
  output logic signed [DW-1:0] y_sat
);
  localparam int PW   = CW + DW;
  localparam int ACCW = PW + 3;

  logic signed [CW-1:0]   c_b0, c_b1, c_b2, c_a1, c_a2, c_lo, c_hi;
  logic signed [PW-1:0]   p_b0, p_b1, p_b2, p_a1, p_a2;
  logic signed [ACCW-1:0] acc, scaled, lo_x, hi_x;

  assign c_b0 = $signed(coef[int'(IDX_B0)*CW +: CW]);
  assign c_b1 = $signed(coef[int'(IDX_B1)*CW +: CW]);
  assign c_b2 = $signed(coef[int'(IDX_B2)*CW +: CW]);
  assign c_a1 = $signed(coef[int'(IDX_A1)*CW +: CW]);
  assign c_a2 = $signed(coef[int'(IDX_A2)*CW +: CW]);
  assign c_lo = $signed(coef[int'(IDX_LO)*CW +: CW]);
  assign c_hi = $signed(coef[int'(IDX_HI)*CW +: CW]);

  assign p_b0 = c_b0 * e0;
  assign p_b1 = c_b1 * e1;
  assign p_b2 = c_b2 * e2;
  assign p_a1 = c_a1 * y1;
  assign p_a2 = c_a2 * y2;

  assign acc    = ACCW'(p_b0) + ACCW'(p_b1) + ACCW'(p_b2) - ACCW'(p_a1) - ACCW'(p_a2);
  assign scaled = acc >>> FRAC;
  assign lo_x   = ACCW'(c_lo);
  assign hi_x   = ACCW'(c_hi);

  always_comb begin
    if (scaled > hi_x)      y_sat = DW'(c_hi);
    else if (scaled < lo_x) y_sat = DW'(c_lo);
    else                    y_sat = scaled[DW-1:0];
  end
endmodule

// File: rtl/iirc_hist.sv
module iirc_hist #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 shift,
  input  logic signed [DW-1:0] e_in,
  input  logic signed [DW-1:0] y_in,
  output logic signed [DW-1:0] e1,
  output logic signed [DW-1:0] e2,
  output logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y2
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      e1 <= '0;
      e2 <= '0;
      y1 <= '0;
      y2 <= '0;
    end else if (shift) begin
      e1 <= e_in;
      e2 <= e1;
      y1 <= y_in;
      y2 <= y1;
    end
  end
endmodule

// File: rtl/iirc_core.sv
module iirc_core
  import iirc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CW   = 18,
  parameter int FRAC = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_ctl,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          swap_req,
  output logic          bank_sel
);
  logic                 fire, apply, eff_bank;
  logic                 act_q, pend_q, ov_q;
  logic [DW-1:0]        out_q;
  logic [NREG*CW-1:0]   act_coef;
  logic signed [DW-1:0] e1, e2, y1, y2, y_new;

  assign in_ready = !clr && (!ov_q || out_ready);
  assign fire     = in_valid && in_ready;
  assign apply    = fire && pend_q;
  assign eff_bank = act_q ^ apply;

  iirc_bank_store #(.DW(DW), .CW(CW)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_bank  (~eff_bank),
    .act_bank (eff_bank),
    .act_coef (act_coef)
  );

  iirc_mac #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_mac (
    .coef  (act_coef),
    .e0    ($signed(in_err)),
    .e1    (e1),
    .e2    (e2),
    .y1    (y1),
    .y2    (y2),
    .y_sat (y_new)
  );

  iirc_hist #(.DW(DW)) u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .shift (fire),
    .e_in  ($signed(in_err)),
    .y_in  (y_new),
    .e1    (e1),
    .e2    (e2),
    .y1    (y1),
    .y2    (y2)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      ov_q   <= 1'b0;
      out_q  <= '0;
    end else begin
      act_q  <= eff_bank;
      pend_q <= (pend_q && !fire) || swap_req;
      if (fire) begin
        ov_q  <= 1'b1;
        out_q <= y_new;
      end else if (out_ready) begin
        ov_q  <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_ctl   = out_q;
  assign bank_sel  = act_q;
endmodule

// File: rtl/iirc_chk.sv
module iirc_chk
  import iirc_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DW-1:0]      out_ctl,
  input logic               bank_sel,
  input logic [NREG*CW-1:0] act_coef
);
  logic signed [CW-1:0] lim_lo, lim_hi, out_x;
  logic                 acc_now;
  assign lim_lo  = $signed(act_coef[int'(IDX_LO)*CW +: CW]);
  assign lim_hi  = $signed(act_coef[int'(IDX_HI)*CW +: CW]);
  assign out_x   = CW'($signed(out_ctl));
  assign acc_now = in_valid && in_ready;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ctl));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc_now));

  assert_clr_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);

  assert_swap_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel != $past(bank_sel)) |-> $past(acc_now));

  assert_active_intact_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_now && !$past(acc_now)) |-> $stable(act_coef));

  assert_in_limits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !acc_now && (lim_lo <= lim_hi)) |-> (out_x >= lim_lo && out_x <= lim_hi));
endmodule

bind iirc_core iirc_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ctl   (out_ctl),
  .bank_sel  (bank_sel),
  .act_coef  (act_coef)
);

// File: tb/sim_iirc_core.sv
module sim_iirc_core;
  localparam int DW = 16;
  localparam int CW = 18;
  localparam int FRAC = 14;

  logic clk = 1'b0;
  logic rst_n, clr, in_valid, in_ready, out_valid, out_ready, wr_en, swap_req, bank_sel;
  logic [DW-1:0] in_err, out_ctl;
  logic [2:0]    wr_addr;
  logic [CW-1:0] wr_data;

  iirc_core #(.DW(DW), .CW(CW), .FRAC(FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_err(in_err), .out_valid(out_valid), .out_ready(out_ready), .out_ctl(out_ctl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .swap_req(swap_req),
    .bank_sel(bank_sel)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";

  longint mb [2][7];
  bit     m_act, m_pend, m_ov;
  longint m_out, me1, me2, my1, my2;

  function automatic longint sx(longint v, int w);
    longint m = v & ((longint'(1) << w) - 1);
    if (m[w-1]) m = m - (longint'(1) << w);
    return m;
  endfunction

  task automatic chk(string t, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 5; i++) mb[b][i] = 0;
      mb[b][5] = -32768;
      mb[b][6] = 32767;
    end
    m_act = 0; m_pend = 0; m_ov = 0; m_out = 0;
    me1 = 0; me2 = 0; my1 = 0; my2 = 0;
  endtask

  task automatic step();
    longint e0, acc, y;
    bit rdy, fire, eff;
    rdy  = !clr && (!m_ov || out_ready);
    fire = in_valid && rdy;
    eff  = m_act ^ (m_pend & fire);
    if (clr) begin me1 = 0; me2 = 0; my1 = 0; my2 = 0; end
    if (fire) begin
      e0  = sx(longint'(in_err), DW);
      acc = mb[eff][0]*e0 + mb[eff][1]*me1 + mb[eff][2]*me2 - mb[eff][3]*my1 - mb[eff][4]*my2;
      y   = acc >>> FRAC;
      if (y > mb[eff][6]) y = mb[eff][6];
      else if (y < mb[eff][5]) y = mb[eff][5];
      me2 = me1; me1 = e0; my2 = my1; my1 = y;
      m_out = y; m_ov = 1;
    end else if (out_ready) begin
      m_ov = 0;
    end
    if (wr_en && wr_addr < 7)
      mb[!eff][wr_addr] = (wr_addr >= 5) ? sx(longint'(wr_data), DW) : sx(longint'(wr_data), CW);
    m_pend = (m_pend && !fire) || swap_req;
    m_act  = eff;
    @(posedge clk);
    @(negedge clk);
    chk("R8 out_valid", out_valid, m_ov);
    chk("R8 in_ready", in_ready, !clr && (!m_ov || out_ready));
    chk("R6 bank_sel", bank_sel, m_act);
    if (m_ov) chk({tag, " out_ctl"}, sx(longint'(out_ctl), DW), m_out);
  endtask

  task automatic drive(bit v, int e, bit ordy, bit we, int a, int d, bit sw, bit c);
    in_valid = v; in_err = DW'(e); out_ready = ordy;
    wr_en = we; wr_addr = 3'(a); wr_data = CW'(d); swap_req = sw; clr = c;
    step();
  endtask

  task automatic wr(int a, int d);
    drive(0, 0, 1, 1, a, d, 0, 0);
  endtask

  task automatic smp(int e);
    drive(1, e, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic swap();
    drive(0, 0, 1, 0, 0, 0, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; in_valid = 0; in_err = '0; out_ready = 1;
    wr_en = 0; wr_addr = '0; wr_data = '0; swap_req = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 bank_sel", bank_sel, 0);
    tag = "R1";
    smp(1000); smp(-1234); drive(0, 0, 1, 0, 0, 0, 0, 0);

    // R4: load bank 1 through the write port, address 7 ignored
    tag = "R4";
    wr(0, 16384); wr(1, -8192); wr(2, 0); wr(3, -8192); wr(4, 0); wr(7, 12345);
    swap();
    tag = "R2";
    smp(100); smp(200); smp(-300); smp(50); smp(0); smp(0);
    // R5: scribble on the inactive bank, outputs keep following the active one
    tag = "R5";
    wr(0, 99999); wr(3, 5000); wr(6, 3);
    smp(400); smp(-400); smp(777);

    // R3: tight limits with large gain
    tag = "R3";
    wr(0, 65536); wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0); wr(5, -500); wr(6, 700);
    swap();
    smp(2000); smp(-2000); smp(100); smp(-100); smp(174); smp(176);
    // R3: crossed limits, upper is checked first
    wr(5, 300); wr(6, -300);
    swap();
    tag = "R6";
    smp(10); smp(-5000); smp(5000);

    // R6: repeated requests merge, request during accept applies later
    swap(); swap(); swap();
    smp(1); smp(2);
    drive(1, 3, 1, 0, 0, 0, 1, 0);
    smp(4); smp(5);

    // R7: write in the same cycle an accept applies a pending swap
    tag = "R7";
    swap();
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    drive(1, 600, 1, 1, 0, 8000, 0, 0);
    smp(600); smp(-50);
    swap();
    smp(1000); smp(1000);

    // R8: back-pressure patterns
    tag = "R8";
    for (int i = 0; i < 400; i++)
      drive($urandom_range(0, 1), int'($urandom_range(0, 4000)) - 2000,
            $urandom_range(0, 3) != 0, 0, 0, 0, 0, 0);
    drive(1, 55, 0, 0, 0, 0, 0, 0);
    drive(1, 66, 0, 0, 0, 0, 0, 0);
    drive(1, 77, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0, 0, 0);

    // R9: clear history mid-stream
    tag = "R9";
    wr(0, 16384); wr(1, 16384); wr(2, 16384); wr(3, -8000); wr(4, 4000); wr(5, -30000); wr(6, 30000);
    swap();
    smp(500); smp(500);
    drive(1, 500, 1, 0, 0, 0, 0, 1);
    smp(500); smp(0); smp(0);

    // random mix
    tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      int a, d;
      a = $urandom_range(0, 7);
      if (a <= 2)      d = int'($urandom_range(0, 40000)) - 20000;
      else if (a <= 4) d = int'($urandom_range(0, 16000)) - 8000;
      else if (a == 5) d = -int'($urandom_range(0, 20000));
      else             d = int'($urandom_range(0, 20000));
      if ($urandom_range(0, 15) == 0) d = -d;
      drive($urandom_range(0, 3) != 0, int'($urandom_range(0, 65535)) - 32768,
            $urandom_range(0, 4) != 0, $urandom_range(0, 2) == 0, a, d,
            $urandom_range(0, 9) == 0, $urandom_range(0, 40) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule